// File: doc/BRIEF.md
# Strobed Receiver Duty-Cycle Sequencer

This block decides when a low-power radio receive path is powered. A countdown, advanced by a tick clock-enable, alternates the receiver between a sleep interval and a listen interval, each set by a small programmable field. The listen countdown starts only once the oscillator reports it is ready. An external strobe can be left released, driven low or driven high. Released lets the countdown run. Low forces sleep. High holds the receiver awake.

While the receiver is listening, a detected identifier or an active message holds it awake until end of message. A low level on the configuration input overrides every other input and parks the block in configuration mode. On each wake-up the block picks the register bank the receiver uses. It either alternates between bank A and bank B or takes a fixed bank. The choice is reported on a registered status output.

Top module: `rx_wake_seq`

## Requirements
- R1: During reset and right after it, `cfg_mode` is 1, and `rx_on` and `bank_b` are 0.
- R2: With the strobe released and the block asleep, `rx_on` rises on the clock after the (off_time+1)-th tick of the sleep interval. Leaving configuration mode loads a fresh sleep interval.
- R3: A wake-up first waits for `osc_ready` with `rx_on` high. From the clock on which `osc_ready` is seen, the listen interval lasts on_time+1 ticks. After that, `rx_on` falls on the next clock and a new sleep interval starts.
- R4: A strobe driven low (`strb_en`=1, `strb_val`=0) drops `rx_on` on the next clock from any state except configuration, and freezes the sleep countdown.
- R5: A strobe driven high (`strb_en`=1, `strb_val`=1) wakes the block from sleep on the next clock and keeps `rx_on` high whatever the countdown does.
- R6: `cfg_n` low puts `cfg_mode` at 1 and `rx_on` at 0 on the next clock, from any state. The first clock with `cfg_n` high enters sleep.
- R7: While listening, `id_det` or `msg_active` holds `rx_on` high, ignoring ticks, until `eom` is seen. After `eom` the block sleeps, or it returns to listening if the strobe is driven high.
- R8: With `auto_bank`=1, successive wake-ups after configuration use bank A (`bank_b`=0), then B, then A, and so on.
- R9: With `auto_bank`=0, `bank_b` takes `man_bank` at each wake-up. `bank_b` never changes while `rx_on` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Interval counting enable |
| cfg_n | input | 1 | Configuration request, active low |
| strb_en | input | 1 | Strobe is driven (0 = released) |
| strb_val | input | 1 | Strobe level when driven |
| osc_ready | input | 1 | Oscillator and synthesiser ready |
| id_det | input | 1 | Identifier detected |
| msg_active | input | 1 | Message reception in progress |
| eom | input | 1 | End of message |
| auto_bank | input | 1 | Alternate banks per wake-up |
| man_bank | input | 1 | Bank used when not alternating |
| off_time | input | OFF_W | Sleep interval field |
| on_time | input | ON_W | Listen interval field |
| rx_on | output | 1 | Receiver enable |
| bank_b | output | 1 | Active bank (1 = B) |
| cfg_mode | output | 1 | Configuration mode active |

## Verification
All three outputs are registered. Every result is due on the first clock edge after the input pattern that causes it, including the tick that ends an interval, a strobe change, `cfg_n` low and `eom`. The bench applies inputs after a falling edge and advances its behavioural model at the next rising edge using those same inputs. It then compares all outputs at the following falling edge, so each comparison sees exactly one edge of latency.

// File: rtl/rx_wake_seq.sv
module rx_wake_seq #(
  parameter int OFF_W = 3,
  parameter int ON_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_n,
  input  logic             strb_en,
  input  logic             strb_val,
  input  logic             osc_ready,
  input  logic             id_det,
  input  logic             msg_active,
  input  logic             eom,
  input  logic             auto_bank,
  input  logic             man_bank,
  input  logic [OFF_W-1:0] off_time,
  input  logic [ON_W-1:0]  on_time,
  output logic             rx_on,
  output logic             bank_b,
  output logic             cfg_mode
);
  localparam int CW = (OFF_W > ON_W) ? OFF_W : ON_W;

  typedef enum logic [2:0] {S_CFG, S_OFF, S_WARM, S_ON, S_HOLD} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          alt;

  wire force_off = strb_en & ~strb_val;
  wire force_on  = strb_en & strb_val;
  wire cnt_zero  = (cnt == '0);
  wire wake      = (st == S_OFF) && (st_n == S_WARM);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!cfg_n) st_n = S_CFG;
    else begin
      case (st)
        S_CFG: begin
          st_n  = S_OFF;
          cnt_n = CW'(off_time);
        end
        S_OFF: begin
          if (force_on) st_n = S_WARM;
          else if (!force_off && tick) begin
            if (cnt_zero) st_n = S_WARM;
            else cnt_n = cnt - 1'b1;
          end
        end
        S_WARM: begin
          if (force_off) begin
            st_n  = S_OFF;
            cnt_n = CW'(off_time);
          end else if (osc_ready) begin
            st_n  = S_ON;
            cnt_n = CW'(on_time);
          end
        end
        S_ON: begin
          if (force_off) begin
            st_n  = S_OFF;
            cnt_n = CW'(off_time);
          end else if (id_det || msg_active) st_n = S_HOLD;
          else if (tick) begin
            if (!cnt_zero) cnt_n = cnt - 1'b1;
            else if (!force_on) begin
              st_n  = S_OFF;
              cnt_n = CW'(off_time);
            end
          end
        end
        S_HOLD: begin
          if (force_off) begin
            st_n  = S_OFF;
            cnt_n = CW'(off_time);
          end else if (eom) begin
            if (force_on) begin
              st_n  = S_ON;
              cnt_n = CW'(on_time);
            end else begin
              st_n  = S_OFF;
              cnt_n = CW'(off_time);
            end
          end
        end
        default: st_n = S_CFG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CFG;
      cnt      <= '0;
      alt      <= 1'b0;
      bank_b   <= 1'b0;
      rx_on    <= 1'b0;
      cfg_mode <= 1'b1;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      rx_on    <= (st_n == S_WARM) || (st_n == S_ON) || (st_n == S_HOLD);
      cfg_mode <= (st_n == S_CFG);
      if (st_n == S_CFG) begin
        alt    <= 1'b0;
        bank_b <= 1'b0;
      end else if (wake) begin
        if (auto_bank) begin
          bank_b <= alt;
          alt    <= ~alt;
        end else begin
          bank_b <= man_bank;
        end
      end
    end
  end

  // R6
  cfg_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n |=> (cfg_mode && !rx_on));

  // R4
  strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_n && strb_en && !strb_val) |=> !rx_on);

  // R5
  strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_n && strb_en && strb_val && !cfg_mode) |=> rx_on);

  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && cfg_n && !eom && !(strb_en && !strb_val)) |=> rx_on);

  // R9
  bank_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && $past(rx_on)) |-> $stable(bank_b));

endmodule

// File: tb/rx_wake_seq_tb.sv
`timescale 1ns/1ps
module rx_wake_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cfg_n = 1, strb_en = 0, strb_val = 0, osc_ready = 0;
  logic id_det = 0, msg_active = 0, eom = 0, auto_bank = 0, man_bank = 0;
  logic [2:0] off_time = 3'd2;
  logic [3:0] on_time = 4'd1;
  logic rx_on, bank_b, cfg_mode;

  int tests = 0, fails = 0;
  string req = "R1";
  // model: 0 config, 1 asleep, 2 waiting ready, 3 listening, 4 message hold
  int m_st = 0, m_cnt = 0, m_alt = 0, m_bank = 0;

  always #2.5 clk = ~clk;

  rx_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_n(cfg_n), .strb_en(strb_en),
    .strb_val(strb_val), .osc_ready(osc_ready), .id_det(id_det),
    .msg_active(msg_active), .eom(eom), .auto_bank(auto_bank),
    .man_bank(man_bank), .off_time(off_time), .on_time(on_time),
    .rx_on(rx_on), .bank_b(bank_b), .cfg_mode(cfg_mode));

  task automatic model_step();
    bit lo = strb_en && !strb_val;
    bit hi = strb_en && strb_val;
    int prev = m_st;
    if (!cfg_n) begin
      m_st = 0; m_alt = 0; m_bank = 0;
      return;
    end
    if (m_st == 0) begin m_st = 1; m_cnt = off_time; end
    else if (m_st == 1) begin
      if (hi) m_st = 2;
      else if (!lo && tick) begin
        if (m_cnt == 0) m_st = 2; else m_cnt--;
      end
    end else if (lo) begin m_st = 1; m_cnt = off_time; end
    else if (m_st == 2) begin
      if (osc_ready) begin m_st = 3; m_cnt = on_time; end
    end else if (m_st == 3) begin
      if (id_det || msg_active) m_st = 4;
      else if (tick) begin
        if (m_cnt > 0) m_cnt--;
        else if (!hi) begin m_st = 1; m_cnt = off_time; end
      end
    end else if (m_st == 4 && eom) begin
      if (hi) begin m_st = 3; m_cnt = on_time; end
      else begin m_st = 1; m_cnt = off_time; end
    end
    if (prev == 1 && m_st == 2) begin
      if (auto_bank) begin m_bank = m_alt; m_alt = 1 - m_alt; end
      else m_bank = man_bank;
    end
  endtask

  task automatic compare();
    bit e_on = (m_st >= 2);
    bit e_cfg = (m_st == 0);
    tests++;
    if (rx_on !== e_on || bank_b !== m_bank[0] || cfg_mode !== e_cfg) begin
      fails++;
      $display("FAIL %s t=%0t rx_on/bank_b/cfg_mode actual %b%b%b expected %b%b%b",
               req, $time, rx_on, bank_b, cfg_mode, e_on, m_bank[0], e_cfg);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #(200000 * 5.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    cyc(1);
    // R2 sleep interval timing with released strobe
    req = "R2"; tick = 1; osc_ready = 0;
    cyc(5);
    // R3 wait for ready, then listen interval
    req = "R3"; cyc(3); osc_ready = 1; cyc(8);
    tick = 0; cyc(2); tick = 1; cyc(6);
    // R6 configuration preempts while listening
    req = "R6"; strb_en = 1; strb_val = 1; cyc(3);
    cfg_n = 0; cyc(3); cfg_n = 1; strb_en = 0; cyc(2);
    // R8 alternating banks
    req = "R8"; auto_bank = 1; off_time = 3'd0; on_time = 4'd0;
    cyc(30);
    // R9 fixed bank
    req = "R9"; auto_bank = 0; man_bank = 1; cyc(10);
    man_bank = 0; cyc(10);
    // R5 strobe high holds on
    req = "R5"; strb_en = 1; strb_val = 1; cyc(12);
    // R4 strobe low forces off, counter frozen
    req = "R4"; strb_val = 0; off_time = 3'd5; cyc(10);
    strb_en = 0; cyc(2);
    // R7 identifier hold until end of message
    req = "R7"; off_time = 3'd1; on_time = 4'd3;
    cyc(4); id_det = 1; cyc(1); id_det = 0; cyc(12);
    msg_active = 1; cyc(3); msg_active = 0; cyc(3);
    eom = 1; cyc(1); eom = 0; cyc(6);
    cyc(4); msg_active = 1; cyc(2); msg_active = 0;
    strb_en = 1; strb_val = 1; eom = 1; cyc(1); eom = 0; cyc(3); strb_en = 0;
    cyc(6);
    // mixed random stimulus across all modes
    req = "R2 R3 R4 R5 R7 R8 R9";
    for (int k = 0; k < 4000; k++) begin
      tick = ($urandom_range(0, 2) != 0);
      osc_ready = ($urandom_range(0, 3) != 0);
      id_det = ($urandom_range(0, 19) == 0);
      msg_active = ($urandom_range(0, 29) == 0);
      eom = ($urandom_range(0, 9) == 0);
      cfg_n = ($urandom_range(0, 99) != 0);
      strb_en = ($urandom_range(0, 7) == 0);
      strb_val = $urandom_range(0, 1);
      man_bank = $urandom_range(0, 1);
      if ($urandom_range(0, 199) == 0) auto_bank = ~auto_bank;
      if ($urandom_range(0, 49) == 0) off_time = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 49) == 0) on_time = 4'($urandom_range(0, 15));
      cyc(1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule